// File: doc/BRIEF.md
# Iterative Integer Multiplier with Multiply-Add

This unit computes signed and unsigned integer products for a 64-bit datapath. It covers ten operations. Three work on the low 32 bits of each operand: a low-word signed product and high-word signed and unsigned products. Three form a 128-bit product from full doublewords: low half, high half signed, and high half unsigned. Three are multiply-add forms that add a third operand to the 128-bit product. The last one multiplies by a sign-extended 16-bit immediate. The result goes to a 64-bit destination value. The unit also returns an overflow flag for the forms that can raise it, and a 4-bit condition field on request.

The operation is issued with a single-cycle `start` pulse. The unit latches what it needs and runs a digit-serial shift-add loop that retires `DIGIT_W` multiplier bits per cycle. It then spends one cycle on sign correction, the addend and result selection. After that, `done` pulses for one cycle. The outputs keep their values until the next completed operation. A `start` that arrives while the unit is busy is ignored.

Top module: `imul_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, the unit returns to idle. After that edge, `busy`, `done`, `result`, `ovf`, `cr_valid` and `cr_field` all read zero.
- R2: A `start` sampled while idle sets `busy` from the next edge. `done` is high for exactly one cycle, beginning at the (64/DIGIT_W + 1)-th rising edge after the edge that sampled `start`. With the defaults that is the 17th edge. `busy` falls at that same edge.
- R3: A `start` that is high while `busy` is high is ignored. The running operation completes with its original operands. No extra `done` follows it.
- R4: For `op_sel` 0 (word low), `result` is the full 64-bit signed product of the low 32 bits of `src_a` and `src_b`; upper operand bits are ignored. `ovf` is 1 when `ovf_en` is set and product bits 63 down to 31 are not all equal.
- R5: For `op_sel` 1 (word high signed) and `op_sel` 2 (word high unsigned), the low 32 bits of `src_a` and `src_b` are multiplied to a 64-bit product. Its bits 63:32 are placed in both `result[63:32]` and `result[31:0]`.
- R6: For `op_sel` 3 (doubleword low), `result` is bits 63:0 of the signed 128-bit product of `src_a` and `src_b`. `ovf` is 1 when `ovf_en` is set and product bits 127 down to 63 are not all equal.
- R7: For `op_sel` 4, `result` is bits 127:64 of the signed 128-bit product. For `op_sel` 5, it is bits 127:64 of the unsigned 128-bit product.
- R8: For the multiply-add forms, `op_sel` 6 gives bits 127:64 of (signed product + sign-extended `src_c`). `op_sel` 7 gives bits 127:64 of (unsigned product + zero-extended `src_c`). `op_sel` 8 gives bits 63:0 of (signed product + sign-extended `src_c`).
- R9: For `op_sel` 9, `result` is bits 63:0 of the signed product of `src_a` and the sign-extended `imm16`.
- R10: When `rec_en` was set with the accepted `start`, `cr_valid` pulses with `done`. It stays low otherwise. `cr_field` is {negative, positive, zero, ovf} from bit 3 down to bit 0, judged on the 64-bit `result`. For `op_sel` 0 to 2, bits 3:1 are unspecified.
- R11: `ovf` is 0 for every `op_sel` other than 0 and 3, and whenever `ovf_en` is clear.
- R12: `result`, `ovf` and `cr_field` change only at the edge that raises `done`. Input activity without an accepted `start` leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Issue pulse, accepted only while idle |
| op_sel | input | 4 | Operation code, 0 to 9 |
| ovf_en | input | 1 | Enables overflow reporting |
| rec_en | input | 1 | Requests the condition field |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand |
| src_c | input | 64 | Addend for multiply-add forms |
| imm16 | input | 16 | Immediate for op 9 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Destination value |
| ovf | output | 1 | Overflow flag |
| cr_valid | output | 1 | Condition field is valid, pulses with done |
| cr_field | output | 4 | {neg, pos, zero, ovf} |

## Verification
The bench targets several corner cases, each tied to a specific wrong behaviour:

- **Most-negative operands**, such as -2^63 and 0x8000_0000 squared. These catch a sign-magnitude path that loses the magnitude of the most negative value.
- **Products that sit exactly on the overflow boundary.** Here 2^31 as a word product, or 2^63 and -2^63 as doubleword products, expose an overflow check that tests one bit too few or too many.
- **Word operands whose upper halves hold noise.** These show whether upper bits leak into word products.
- **High-word forms with mixed signs.** These reveal a missing copy into the low half, or signed and unsigned treatment swapped.
- **Multiply-add with a negative addend against an unsigned product.** This separates sign extension from zero extension of the third operand.
- **A second `start` inside the busy window, and input changes after completion.** These catch a unit that re-latches operands mid-run or lets its outputs drift.

// File: rtl/imul_pkg.sv
// Package: shared types for the iterative integer multiplier.
// Assumes a 4-bit operation code; codes 10..15 are unused.
package imul_pkg;

    typedef enum logic [3:0] {
        OP_MUL_WLO  = 4'd0,
        OP_MUL_WHI  = 4'd1,
        OP_MUL_WHIU = 4'd2,
        OP_MUL_DLO  = 4'd3,
        OP_MUL_DHI  = 4'd4,
        OP_MUL_DHIU = 4'd5,
        OP_MAC_DHI  = 4'd6,
        OP_MAC_DHIU = 4'd7,
        OP_MAC_DLO  = 4'd8,
        OP_MUL_IMM  = 4'd9
    } mul_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } mul_state_e;

endpackage

// File: rtl/imul_prep.sv
// Module: imul_prep
// Turns raw operands into unsigned magnitudes, a product sign and an addend.
// Word forms extend the low half of each operand. Combinational only;
// assumes DATA_W is even and larger than IMM_W.
module imul_prep
    import imul_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 16
) (
    input  mul_op_e               op,
    input  logic [DATA_W-1:0]     opa,
    input  logic [DATA_W-1:0]     opb,
    input  logic [DATA_W-1:0]     opc,
    input  logic [IMM_W-1:0]      imm,
    output logic [DATA_W-1:0]     mag_a,
    output logic [DATA_W-1:0]     mag_b,
    output logic                  neg,
    output logic [2*DATA_W-1:0]   addend
);
    localparam int HALF = DATA_W / 2;

    logic [DATA_W-1:0] ext_a;
    logic [DATA_W-1:0] ext_b;
    logic              is_signed;
    logic              neg_a;
    logic              neg_b;

    // Select and extend the operands for the requested form.
    always_comb begin
        ext_a     = opa;
        ext_b     = opb;
        is_signed = 1'b1;
        case (op)
            OP_MUL_WLO, OP_MUL_WHI: begin
                ext_a = {{HALF{opa[HALF-1]}}, opa[HALF-1:0]};
                ext_b = {{HALF{opb[HALF-1]}}, opb[HALF-1:0]};
            end
            OP_MUL_WHIU: begin
                ext_a     = {{HALF{1'b0}}, opa[HALF-1:0]};
                ext_b     = {{HALF{1'b0}}, opb[HALF-1:0]};
                is_signed = 1'b0;
            end
            OP_MUL_DHIU, OP_MAC_DHIU: is_signed = 1'b0;
            OP_MUL_IMM: ext_b = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
            default: ;
        endcase
    end

    // Fold signed operands to magnitudes and record the product sign.
    always_comb begin
        neg_a = is_signed & ext_a[DATA_W-1];
        neg_b = is_signed & ext_b[DATA_W-1];
        mag_a = neg_a ? (~ext_a + 1'b1) : ext_a;
        mag_b = neg_b ? (~ext_b + 1'b1) : ext_b;
        neg   = neg_a ^ neg_b;
    end

    // Build the third-operand addend at full product width.
    always_comb begin
        case (op)
            OP_MAC_DHI, OP_MAC_DLO: addend = {{DATA_W{opc[DATA_W-1]}}, opc};
            OP_MAC_DHIU:            addend = {{DATA_W{1'b0}}, opc};
            default:                addend = '0;
        endcase
    end
endmodule

// File: rtl/imul_core.sv
// Module: imul_core
// Digit-serial unsigned shift-add multiplier. Each step consumes DIGIT_W
// multiplier bits from the bottom of the product register and shifts the
// register right. Assumes DATA_W is a multiple of DIGIT_W. After
// DATA_W/DIGIT_W steps, prod holds the full unsigned product.
module imul_core #(
    parameter int DATA_W  = 64,
    parameter int DIGIT_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                step,
    input  logic [DATA_W-1:0]   mag_a,
    input  logic [DATA_W-1:0]   mag_b,
    output logic [2*DATA_W-1:0] prod
);
    localparam int SUM_W = DATA_W + DIGIT_W;

    logic [DATA_W-1:0]   mcand_q;
    logic [2*DATA_W-1:0] prod_q;
    logic [SUM_W-1:0]    part [DIGIT_W];
    logic [SUM_W-1:0]    hi_sum;

    // One shifted copy of the multiplicand per digit bit.
    for (genvar g = 0; g < DIGIT_W; g++) begin : g_part
        assign part[g] = prod_q[g] ? ({{DIGIT_W{1'b0}}, mcand_q} << g) : '0;
    end

    // Accumulate the digit's partial products onto the upper half.
    always_comb begin
        hi_sum = {{DIGIT_W{1'b0}}, prod_q[2*DATA_W-1:DATA_W]};
        for (int i = 0; i < DIGIT_W; i++) begin
            hi_sum = hi_sum + part[i];
        end
    end

    // Load operands or retire one digit per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q <= '0;
            prod_q  <= '0;
        end else if (load) begin
            mcand_q <= mag_a;
            prod_q  <= {{DATA_W{1'b0}}, mag_b};
        end else if (step) begin
            prod_q  <= {hi_sum, prod_q[DATA_W-1:DIGIT_W]};
        end
    end

    assign prod = prod_q;
endmodule

// File: rtl/imul_fmt.sv
// Module: imul_fmt
// Applies the product sign, adds the addend and selects the destination
// value, overflow flag and condition field. Combinational; assumes an
// unsigned magnitude product at its input.
module imul_fmt
    import imul_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  mul_op_e               op,
    input  logic                  ovf_en,
    input  logic [2*DATA_W-1:0]   prod,
    input  logic                  neg,
    input  logic [2*DATA_W-1:0]   addend,
    output logic [DATA_W-1:0]     res,
    output logic                  ovf,
    output logic [3:0]            cr
);
    localparam int HALF = DATA_W / 2;

    logic [2*DATA_W-1:0] prod_s;
    logic [2*DATA_W-1:0] total;
    logic                word_ov;
    logic                dword_ov;

    // Restore the sign and add the third operand.
    always_comb begin
        prod_s = neg ? (~prod + 1'b1) : prod;
        total  = prod_s + addend;
    end

    // Overflow tests: the kept slice must be a uniform sign run.
    always_comb begin
        word_ov  = !((&prod_s[DATA_W-1:HALF-1]) || (~|prod_s[DATA_W-1:HALF-1]));
        dword_ov = !((&prod_s[2*DATA_W-1:DATA_W-1]) || (~|prod_s[2*DATA_W-1:DATA_W-1]));
    end

    // Pick the destination value and overflow per form.
    always_comb begin
        ovf = 1'b0;
        case (op)
            OP_MUL_WLO: begin
                res = prod_s[DATA_W-1:0];
                ovf = ovf_en & word_ov;
            end
            OP_MUL_WHI, OP_MUL_WHIU:
                res = {prod_s[DATA_W-1:HALF], prod_s[DATA_W-1:HALF]};
            OP_MUL_DHI, OP_MUL_DHIU:
                res = prod_s[2*DATA_W-1:DATA_W];
            OP_MAC_DHI, OP_MAC_DHIU:
                res = total[2*DATA_W-1:DATA_W];
            OP_MAC_DLO:
                res = total[DATA_W-1:0];
            OP_MUL_IMM:
                res = prod_s[DATA_W-1:0];
            default: begin
                res = prod_s[DATA_W-1:0];
                ovf = ovf_en & dword_ov;
            end
        endcase
    end

    // Condition field: negative, positive, zero, overflow.
    always_comb begin
        cr[3] = res[DATA_W-1];
        cr[2] = !res[DATA_W-1] && (res != '0);
        cr[1] = (res == '0);
        cr[0] = ovf;
    end
endmodule

// File: rtl/imul_unit.sv
// Module: imul_unit (top)
// Start/done sequencer around prep, core and format stages. Operands are
// captured on an accepted start; start is ignored while busy. Latency is
// DATA_W/DIGIT_W core steps plus one format cycle. Outputs hold until the
// next completion.
module imul_unit
    import imul_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int DIGIT_W = 4,
    parameter int IMM_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        op_sel,
    input  logic              ovf_en,
    input  logic              rec_en,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [DATA_W-1:0] src_c,
    input  logic [IMM_W-1:0]  imm16,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result,
    output logic              ovf,
    output logic              cr_valid,
    output logic [3:0]        cr_field
);
    localparam int STEPS = DATA_W / DIGIT_W;
    localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

    mul_state_e          state_q;
    logic [CNT_W-1:0]    cnt_q;
    mul_op_e             op_in;
    mul_op_e             op_q;
    logic                ovf_en_q;
    logic                rec_en_q;
    logic                neg_q;
    logic [2*DATA_W-1:0] addend_q;

    logic [DATA_W-1:0]   mag_a;
    logic [DATA_W-1:0]   mag_b;
    logic                neg_d;
    logic [2*DATA_W-1:0] addend_d;
    logic [2*DATA_W-1:0] prod;
    logic [DATA_W-1:0]   fmt_res;
    logic                fmt_ovf;
    logic [3:0]          fmt_cr;
    logic                accept;

    logic [DATA_W-1:0]   result_q;
    logic                ovf_q;
    logic [3:0]          cr_q;
    logic                done_q;
    logic                cr_valid_q;

    assign op_in  = mul_op_e'(op_sel);
    assign accept = (state_q == ST_IDLE) && start;

    imul_prep #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_prep (
        .op     (op_in),
        .opa    (src_a),
        .opb    (src_b),
        .opc    (src_c),
        .imm    (imm16),
        .mag_a  (mag_a),
        .mag_b  (mag_b),
        .neg    (neg_d),
        .addend (addend_d)
    );

    imul_core #(.DATA_W(DATA_W), .DIGIT_W(DIGIT_W)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .step  (state_q == ST_RUN),
        .mag_a (mag_a),
        .mag_b (mag_b),
        .prod  (prod)
    );

    imul_fmt #(.DATA_W(DATA_W)) u_fmt (
        .op     (op_q),
        .ovf_en (ovf_en_q),
        .prod   (prod),
        .neg    (neg_q),
        .addend (addend_q),
        .res    (fmt_res),
        .ovf    (fmt_ovf),
        .cr     (fmt_cr)
    );

    // Sequence the operation and capture the finished outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            op_q       <= OP_MUL_WLO;
            ovf_en_q   <= 1'b0;
            rec_en_q   <= 1'b0;
            neg_q      <= 1'b0;
            addend_q   <= '0;
            result_q   <= '0;
            ovf_q      <= 1'b0;
            cr_q       <= '0;
            done_q     <= 1'b0;
            cr_valid_q <= 1'b0;
        end else begin
            done_q     <= 1'b0;
            cr_valid_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        op_q     <= op_in;
                        ovf_en_q <= ovf_en;
                        rec_en_q <= rec_en;
                        neg_q    <= neg_d;
                        addend_q <= addend_d;
                        cnt_q    <= '0;
                        state_q  <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST) begin
                        state_q <= ST_FIN;
                    end
                end
                ST_FIN: begin
                    result_q   <= fmt_res;
                    ovf_q      <= fmt_ovf;
                    cr_q       <= fmt_cr;
                    done_q     <= 1'b1;
                    cr_valid_q <= rec_en_q;
                    state_q    <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign done     = done_q;
    assign result   = result_q;
    assign ovf      = ovf_q;
    assign cr_valid = cr_valid_q;
    assign cr_field = cr_q;
endmodule

// File: rtl/imul_unit_chk.sv
// Module: imul_unit_chk
// Port-level protocol checks for imul_unit, attached by bind below.
module imul_unit_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] result,
    input logic              ovf,
    input logic              cr_valid,
    input logic [3:0]        cr_field
);
    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R3
    busy_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R12
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(result) && $stable(ovf) && $stable(cr_field)));

    // R10
    cr_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cr_valid |-> done);

    // R10
    cr_so_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cr_valid |-> (cr_field[0] == ovf));
endmodule

bind imul_unit imul_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .result   (result),
    .ovf      (ovf),
    .cr_valid (cr_valid),
    .cr_field (cr_field)
);

// File: tb/imul_unit_tb.sv
`timescale 1ns/1ps
// Directed bench for imul_unit; reference is a plain 128-bit multiply.
module imul_unit_tb;
    localparam int LAT = 64 / 4 + 2;   // negedges from start drive to done

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  op_sel = '0;
    logic        ovf_en = 1'b0;
    logic        rec_en = 1'b0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic [63:0] src_c = '0;
    logic [15:0] imm16 = '0;
    logic        busy, done, ovf, cr_valid;
    logic [63:0] result;
    logic [3:0]  cr_field;

    int checks = 0;
    int errors = 0;

    imul_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
        .ovf_en(ovf_en), .rec_en(rec_en), .src_a(src_a), .src_b(src_b),
        .src_c(src_c), .imm16(imm16), .busy(busy), .done(done),
        .result(result), .ovf(ovf), .cr_valid(cr_valid), .cr_field(cr_field)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    function automatic logic [127:0] sx32(input logic [63:0] v);
        return {{96{v[31]}}, v[31:0]};
    endfunction
    function automatic logic [127:0] zx32(input logic [63:0] v);
        return {96'b0, v[31:0]};
    endfunction
    function automatic logic [127:0] sx64(input logic [63:0] v);
        return {{64{v[63]}}, v};
    endfunction
    function automatic logic [127:0] zx64(input logic [63:0] v);
        return {64'b0, v};
    endfunction

    // Reference model built from the requirement text.
    task automatic ref_calc(input logic [3:0] op, input logic [63:0] a, b, c,
                            input logic [15:0] im, input logic oe,
                            output logic [63:0] r, output logic v);
        logic [127:0] q;
        v = 1'b0;
        case (op)
            4'd0: begin q = sx32(a) * sx32(b); r = q[63:0];
                        v = oe && (q[63:0] != {{32{q[31]}}, q[31:0]}); end
            4'd1: begin q = sx32(a) * sx32(b); r = {q[63:32], q[63:32]}; end
            4'd2: begin q = zx32(a) * zx32(b); r = {q[63:32], q[63:32]}; end
            4'd3: begin q = sx64(a) * sx64(b); r = q[63:0];
                        v = oe && (q != {{64{q[63]}}, q[63:0]}); end
            4'd4: begin q = sx64(a) * sx64(b); r = q[127:64]; end
            4'd5: begin q = zx64(a) * zx64(b); r = q[127:64]; end
            4'd6: begin q = sx64(a) * sx64(b) + sx64(c); r = q[127:64]; end
            4'd7: begin q = zx64(a) * zx64(b) + zx64(c); r = q[127:64]; end
            4'd8: begin q = sx64(a) * sx64(b) + sx64(c); r = q[63:0]; end
            default: begin q = sx64(a) * {{112{im[15]}}, im}; r = q[63:0]; end
        endcase
    endtask

    // Issue one operation and wait for done; returns negedges waited.
    task automatic issue(input logic [3:0] op, input logic [63:0] a, b, c,
                         input logic [15:0] im, input logic oe, rec, output int lat);
        @(negedge clk);
        op_sel = op; src_a = a; src_b = b; src_c = c; imm16 = im;
        ovf_en = oe; rec_en = rec; start = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
            if (lat == 1) start = 1'b0;
        end while (!done && lat < 200);
    endtask

    // Run one case and check every output against the reference.
    task automatic run_case(input string tag, input logic [3:0] op,
                            input logic [63:0] a, b, c, input logic [15:0] im,
                            input logic oe, rec);
        int lat;
        logic [63:0] er;
        logic ev;
        logic [3:0] ecr, mask;
        ref_calc(op, a, b, c, im, oe, er, ev);
        issue(op, a, b, c, im, oe, rec, lat);
        check({tag, " result"}, result, er);
        check({tag, " R11 ovf"}, {63'b0, ovf}, {63'b0, ev});
        check("R2 latency", 64'(lat), 64'(LAT));
        check({"R10 cr_valid ", tag}, {63'b0, cr_valid}, {63'b0, rec});
        if (rec) begin
            ecr  = {er[63], !er[63] && (er != 0), er == 0, ev};
            mask = (op <= 4'd2) ? 4'b0001 : 4'b1111;
            check({"R10 cr_field ", tag}, {60'b0, cr_field & mask}, {60'b0, ecr & mask});
        end
    endtask

    task automatic t_reset();
        check("R1 busy", {63'b0, busy}, 64'd0);
        check("R1 done", {63'b0, done}, 64'd0);
        check("R1 result", result, 64'd0);
        check("R1 ovf", {63'b0, ovf}, 64'd0);
        check("R1 cr", {59'b0, cr_valid, cr_field}, 64'd0);
    endtask

    task automatic t_word_low();
        run_case("R4 small", 4'd0, 64'd3, 64'd5, 0, 0, 1, 1);
        run_case("R4 noise", 4'd0, 64'hdeadbeef_fffffffd, 64'h12345678_00000007, 0, 0, 1, 1);
        run_case("R4 ovf", 4'd0, 64'h7fffffff, 64'd2, 0, 0, 1, 1);
        run_case("R4 m1sq", 4'd0, 64'hffffffff, 64'hffffffff, 0, 0, 1, 1);
        run_case("R4 2p31", 4'd0, 64'h10000, 64'h8000, 0, 0, 1, 0);
        run_case("R4 m2p31", 4'd0, 64'h10000, 64'hffff8000, 0, 0, 1, 0);
        run_case("R4 minsq", 4'd0, 64'h80000000, 64'h80000000, 0, 0, 1, 1);
        run_case("R4 R11 oe0", 4'd0, 64'h7fffffff, 64'h7fffffff, 0, 0, 0, 1);
    endtask

    task automatic t_word_high();
        run_case("R5 signed", 4'd1, 64'hffff_ffff_8000_0001, 64'h0000_0000_7fff_ffff, 0, 0, 1, 1);
        run_case("R5 mixed", 4'd1, 64'h0000_0000_ffff_fff0, 64'h0000_0000_0012_3456, 0, 0, 0, 0);
        run_case("R5 unsigned", 4'd2, 64'haaaa_0000_ffff_fff0, 64'h5555_0000_0012_3456, 0, 0, 1, 1);
    endtask

    task automatic t_dword();
        run_case("R6 basic", 4'd3, 64'h0123_4567_89ab_cdef, 64'd1000, 0, 0, 1, 1);
        run_case("R6 ovf", 64'd3, 64'h4000_0000_0000_0000, 64'd2, 0, 0, 1, 1);
        run_case("R6 minx1", 4'd3, 64'h8000_0000_0000_0000, 64'd1, 0, 0, 1, 1);
        run_case("R6 minxm1", 4'd3, 64'h8000_0000_0000_0000, 64'hffff_ffff_ffff_ffff, 0, 0, 1, 1);
        run_case("R7 hi s", 4'd4, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 0, 0, 1, 1);
        run_case("R7 hi s neg", 4'd4, 64'hffff_ffff_ffff_fffe, 64'h7fff_ffff_ffff_ffff, 0, 0, 1, 1);
        run_case("R7 hi u", 4'd5, 64'hffff_ffff_ffff_ffff, 64'hffff_ffff_ffff_ffff, 0, 0, 1, 1);
    endtask

    task automatic t_madd();
        run_case("R8 hi s", 4'd6, 64'hffff_ffff_ffff_ffff, 64'd1, 64'hffff_ffff_ffff_ffff, 0, 1, 1);
        run_case("R8 hi u", 4'd7, 64'hffff_ffff_ffff_ffff, 64'hffff_ffff_ffff_ffff, 64'hffff_ffff_ffff_ffff, 0, 1, 1);
        run_case("R8 hi u2", 4'd7, 64'h8000_0000_0000_0000, 64'd2, 64'hffff_ffff_ffff_ffff, 0, 0, 0);
        run_case("R8 lo s", 4'd8, 64'hffff_ffff_ffff_fffd, 64'd7, 64'h8000_0000_0000_0005, 0, 1, 1);
        run_case("R8 zero", 4'd8, 64'd6, 64'd7, 64'hffff_ffff_ffff_ffd6, 0, 1, 1);
    endtask

    task automatic t_imm();
        run_case("R9 neg", 4'd9, 64'h0000_0001_0000_0003, 64'hffff, 0, 16'hfffb, 1, 1);
        run_case("R9 pos", 4'd9, 64'hffff_ffff_ffff_fff0, 64'd9, 0, 16'h7fff, 1, 1);
    endtask

    task automatic t_busy_ignore();
        int lat;
        int extra;
        logic [63:0] er;
        logic ev;
        ref_calc(4'd3, 64'h1111, 64'h2222, 0, 0, 1'b0, er, ev);
        @(negedge clk);
        op_sel = 4'd3; src_a = 64'h1111; src_b = 64'h2222; ovf_en = 0; rec_en = 0;
        start = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
            if (lat == 1) begin
                start = 1'b0;
                check("R2 busy rise", {63'b0, busy}, 64'd1);
            end
            if (lat == 5) begin
                start = 1'b1; op_sel = 4'd5; src_a = '1; src_b = '1;
            end
            if (lat == 6) start = 1'b0;
        end while (!done && lat < 200);
        check("R3 result", result, er);
        check("R3 latency", 64'(lat), 64'(LAT));
        check("R2 busy low", {63'b0, busy}, 64'd0);
        extra = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (done) extra++;
        end
        check("R3 no extra done", 64'(extra), 64'd0);
    endtask

    task automatic t_hold();
        logic [63:0] keep;
        logic [3:0] kcr;
        run_case("R12 prep", 4'd3, 64'h4000_0000_0000_0000, 64'd4, 0, 0, 1, 1);
        keep = result;
        kcr = cr_field;
        @(negedge clk);
        op_sel = 4'd0; src_a = 64'd9; src_b = 64'd9; ovf_en = 0;
        repeat (25) @(negedge clk);
        check("R12 result hold", result, keep);
        check("R12 cr hold", {60'b0, cr_field}, {60'b0, kcr});
        check("R12 ovf hold", {63'b0, ovf}, 64'd1);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_word_low();
        t_word_high();
        t_dword();
        t_madd();
        t_imm();
        t_busy_ignore();
        t_hold();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule